// File: doc/BRIEF.md
# Two-Wire Bus Slave with 7/10-Bit Address Matching

This block is the target side of a two-wire serial bus running at Standard or Fast speed. It samples the clock and data lines with the system clock, recognises START, repeated START and STOP, and follows the byte-plus-acknowledge framing. It acknowledges the address of the controller. It then delivers written bytes to the host, or sends host-supplied bytes back when the controller reads. A mode input picks 7-bit or 10-bit addressing. The own address is a 10-bit input. In 7-bit mode only its low seven bits take part in the match.

Written bytes pass from a shift register into a one-entry receive buffer that the host drains over a valid/ready pair. Back-pressure rules for that buffer: the byte stays on `rx_data` with `rx_valid` high until a cycle with `rx_ready` high. A bus byte that completes while the buffer is still full is refused at the bus level with a NACK. A byte that completes in the same cycle the host drains the buffer is accepted.

The transmit side is a single register. It is loaded over `tx_valid`/`tx_ready`, and `tx_ready` stays low while a byte waits to be sent. Whenever the controller wants a byte, the block holds the clock line low. It keeps the line low until the host has loaded the register and pulses `scl_release`. Both the arrival of a received byte and the start of such a hold raise a one-cycle `irq`.

Top module: `i2c_tenbit_slave`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid`, `rx_ovf` and `irq` are 0 and `tx_ready` is 1. An output `*_oe` of 1 means that line is pulled low.
- R2: With `addr_mode10`=0, a first byte equal to {own_addr[6:0], rw} (address in bits 7:1, rw in bit 0) is ACKed. Any other first byte is NACKed, and the data bytes that follow are neither ACKed nor delivered.
- R3: With `addr_mode10`=1, a first byte 11110 followed by own_addr[9:8] and rw=0 is ACKed. A second byte equal to own_addr[7:0] is then ACKed and selects the slave for writing. A mismatch in either byte gives a NACK.
- R4: In 10-bit mode, after a repeated START that follows a full two-byte match, the header byte 11110, own_addr[9:8], rw=1 alone is ACKed and starts a read. The same header without a prior full match since the last STOP is NACKed.
- R5: A written byte that completes while the buffer can take it is ACKed and shown on `rx_data` with `rx_valid`=1. It comes with a one-cycle `irq`, and it stays unchanged until a cycle with `rx_ready`=1.
- R6: A written byte that completes while `rx_valid`=1 and `rx_ready`=0 is NACKed and sets `rx_ovf`, and `rx_data` keeps its old value. `rx_ovf` clears at the next START or repeated START.
- R7: A written byte that completes in the same cycle as a host drain (`rx_valid`=1, `rx_ready`=1) is accepted and ACKed and replaces the drained byte, with `rx_ovf` staying 0.
- R8: After a read address is ACKed, and after every byte that the controller ACKs during a read, the slave raises `scl_oe` and pulses `irq`.
- R9: A held clock is let go only when `scl_release` is pulsed while the transmit register holds a byte. A pulse while `tx_ready`=1 is ignored and `scl_oe` stays 1.
- R10: Read bytes go out MSB first. `tx_ready` is 0 from a load until the byte is taken at release. A NACK from the controller ends the read without any further hold.
- R11: The slave changes the data line only while the clock line is low. START is a falling data edge and STOP a rising data edge, each while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_mode10 | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own slave address |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_ready | input | 1 | Host drains the receive buffer |
| rx_data | output | 8 | Received byte |
| rx_ovf | output | 1 | A byte was refused because the buffer was full |
| tx_valid | input | 1 | Host offers a byte to transmit |
| tx_ready | output | 1 | Transmit register is empty |
| tx_data | input | 8 | Byte to transmit |
| scl_release | input | 1 | Pulse to let go of a held clock line |
| irq | output | 1 | One-cycle pulse on byte arrival or on hold start |

## Verification
Two events can land on the same clock edge: a written byte completing in the shift register and the host draining the receive buffer. Which of them the buffer honours first decides between ACK and NACK. The bench uses the fixed two-stage line synchroniser to count cycles from the falling clock edge after the eighth bit. It raises `rx_ready` for exactly the cycle in which the acknowledge decision is registered. It then expects an ACK on the line, the new byte in `rx_data` and no overflow. A second case leaves the buffer full with no drain, and there the bench expects a NACK, `rx_ovf` set and the old byte still in place.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 4;
  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_LOW,
    PH_WR,
    PH_RDACK,
    PH_RD,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
(
  input  logic              mode10_i,
  input  logic [ADDR_W-1:0] own_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              low_phase_i,
  input  logic              sel10_i,
  output logic              ack_o,
  output phase_t            next_o,
  output logic              sel10_o
);
  always_comb begin
    ack_o   = 1'b0;
    next_o  = PH_SKIP;
    sel10_o = 1'b0;
    if (low_phase_i) begin
      if (byte_i == own_i[7:0]) begin
        ack_o   = 1'b1;
        next_o  = PH_WR;
        sel10_o = 1'b1;
      end
    end else if (!mode10_i) begin
      if (byte_i[7:1] == own_i[6:0]) begin
        ack_o  = 1'b1;
        next_o = byte_i[0] ? PH_RDACK : PH_WR;
      end
    end else if (byte_i[7:3] == HDR10_TAG && byte_i[2:1] == own_i[9:8]) begin
      if (!byte_i[0]) begin
        ack_o  = 1'b1;
        next_o = PH_LOW;
      end else if (sel10_i) begin
        ack_o   = 1'b1;
        next_o  = PH_RDACK;
        sel10_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_rxbuf.sv
module i2cs_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_ovf_i,
  input  logic         ready_i,
  output logic         accept_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  assign accept_o = ~valid_o | ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (done_i && accept_o) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
      if (done_i && !accept_o) ovf_o <= 1'b1;
      else if (clr_ovf_i)      ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_txreg.sv
module i2cs_txreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic         ready_o,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  assign ready_o = ~full_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (valid_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/i2c_tenbit_slave.sv
module i2c_tenbit_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              addr_mode10,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_ovf,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              scl_release,
  output logic              irq
);
  localparam int LINES = 2;
  localparam int L_SCL = 1;
  localparam int L_SDA = 0;
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_SLOT = CNT_W'(BYTE_W + 1);

  // line conditioning, one synchroniser per line
  logic [LINES-1:0] raw, lvl, rise, fall;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[g]),
      .lvl_o  (lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic ev_start, ev_stop, scl_up, scl_dn, sda_s;
  assign ev_start = lvl[L_SCL] & fall[L_SDA];
  assign ev_stop  = lvl[L_SCL] & rise[L_SDA];
  assign scl_up   = rise[L_SCL];
  assign scl_dn   = fall[L_SCL];
  assign sda_s    = lvl[L_SDA];

  // protocol state
  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx_sh;
  logic              sda_q, scl_q, rel_pend, sel10, mnack, irq_q;

  logic active;
  assign active = (phase != PH_IDLE) && (phase != PH_SKIP);

  // address decision
  logic   m_ack, m_sel10;
  phase_t m_next;

  i2cs_addr_match u_match (
    .mode10_i    (addr_mode10),
    .own_i       (own_addr),
    .byte_i      (shreg),
    .low_phase_i (phase == PH_LOW),
    .sel10_i     (sel10),
    .ack_o       (m_ack),
    .next_o      (m_next),
    .sel10_o     (m_sel10)
  );

  // receive buffer
  logic wr_done, rx_accept;
  assign wr_done = !ev_start && !ev_stop && scl_dn && (bitcnt == ACK_SLOT) && (phase == PH_WR);

  i2cs_rxbuf #(.W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (wr_done),
    .data_i    (shreg),
    .clr_ovf_i (ev_start),
    .ready_i   (rx_ready),
    .accept_o  (rx_accept),
    .valid_o   (rx_valid),
    .data_o    (rx_data),
    .ovf_o     (rx_ovf)
  );

  // transmit register
  logic              tx_full, take;
  logic [BYTE_W-1:0] tx_q;
  assign take = scl_q && !rel_pend && tx_full && scl_release;

  i2cs_txreg #(.W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (tx_valid),
    .data_i  (tx_data),
    .take_i  (take),
    .ready_o (tx_ready),
    .full_o  (tx_full),
    .data_o  (tx_q)
  );

  // a hold begins after the acknowledge slot of a read address or an acked read byte
  logic hold_go;
  assign hold_go = !ev_start && !ev_stop && scl_dn && (bitcnt == END_SLOT) &&
                   ((phase == PH_RDACK) || (phase == PH_RD && !mnack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      sda_q    <= 1'b0;
      scl_q    <= 1'b0;
      rel_pend <= 1'b0;
      sel10    <= 1'b0;
      mnack    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= (wr_done && rx_accept) || hold_go;
      if (rel_pend) begin
        scl_q    <= 1'b0;
        rel_pend <= 1'b0;
      end
      if (ev_start) begin
        phase  <= PH_HDR;
        bitcnt <= '0;
        sda_q  <= 1'b0;
      end else if (ev_stop) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        sda_q  <= 1'b0;
        sel10  <= 1'b0;
      end else begin
        if (take) begin
          tx_sh    <= tx_q;
          sda_q    <= ~tx_q[BYTE_W-1];
          bitcnt   <= '0;
          rel_pend <= 1'b1;
        end
        if (scl_up && active) begin
          if (bitcnt < ACK_SLOT) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end else begin
            bitcnt <= END_SLOT;
            if (phase == PH_RD) mnack <= sda_s;
          end
        end
        if (scl_dn && active) begin
          if (bitcnt != '0 && bitcnt < ACK_SLOT) begin
            if (phase == PH_RD) sda_q <= ~tx_sh[BYTE_W-1];
          end else if (bitcnt == ACK_SLOT) begin
            unique case (phase)
              PH_HDR, PH_LOW: begin
                sda_q <= m_ack;
                phase <= m_next;
                sel10 <= m_sel10;
              end
              PH_WR:   sda_q <= rx_accept;
              default: sda_q <= 1'b0;
            endcase
          end else if (bitcnt == END_SLOT) begin
            sda_q  <= 1'b0;
            bitcnt <= '0;
            if (phase == PH_RDACK) begin
              phase <= PH_RD;
              scl_q <= 1'b1;
            end else if (phase == PH_RD) begin
              if (mnack) phase <= PH_SKIP;
              else       scl_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sda_oe = sda_q;
  assign scl_oe = scl_q;
  assign irq    = irq_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_ovf,
  input logic       scl_release,
  input logic       irq
);
  // R11: data is pulled low only while the clock line is low
  a_r11_sda_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R5: interrupt is a single-cycle pulse
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: a full buffer without drain keeps its byte
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R6: overflow never disturbs the stored byte
  a_r6_ovf_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> (rx_valid && $stable(rx_data)));

  // R8: each hold start comes with an interrupt
  a_r8_irq_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> irq);

  // R9: the clock is let go only after a release pulse
  a_r9_release_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(scl_release, 2));
endmodule

bind i2c_tenbit_slave i2cs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .rx_ovf      (rx_ovf),
  .scl_release (scl_release),
  .irq         (irq)
);

// File: tb/i2c_tenbit_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_tenbit_slave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe, addr_mode10, rx_valid, rx_ready, rx_ovf;
  logic tx_valid, tx_ready, scl_release, irq;
  logic [9:0] own_addr;
  logic [7:0] rx_data, tx_data;

  int total = 0, bad = 0, irq_cnt = 0, hold_cnt = 0, r11_viol = 0;
  bit done = 0;

  // responder state
  bit sw_en = 0, sw_empty_try = 0;
  int sw_idx = 0;
  logic [7:0] tx_bytes [0:3];

  always #10 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tenbit_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_mode10(addr_mode10),
    .own_addr(own_addr), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ovf(rx_ovf), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .scl_release(scl_release),
    .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt++;
  always @(posedge scl_oe) hold_cnt++;
  always @(posedge sda_oe) if (scl_line === 1'b1) r11_viol++;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hdr(bit m10, logic [9:0] own, logic [7:0] b, bit sel);
    if (!m10) return b[7:1] == own[6:0];
    return (b[7:3] == 5'b11110) && (b[2:1] == own[9:8]) && (!b[0] || sel);
  endfunction

  function automatic bit exp_low(logic [9:0] own, logic [7:0] b);
    return b == own[7:0];
  endfunction

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    int t = 0;
    while (scl_line !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk(0, "R9 clock never let go", 0, 1);
  endtask

  task automatic m_start();
    sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic m_rstart();
    sda_m = 1; wq(Q); scl_m = 1; wait_high(); wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic m_stop();
    sda_m = 0; wq(Q); scl_m = 1; wait_high(); wq(Q); sda_m = 1; wq(2 * Q);
  endtask

  task automatic m_bit_w(bit b, bit race);
    sda_m = b; wq(Q); scl_m = 1; wait_high(); wq(2 * Q); scl_m = 0;
    if (race) begin
      // decision edge is the third edge after the falling clock is driven
      wq(2); rx_ready = 1; wq(1); rx_ready = 0; wq(Q - 3);
    end else wq(Q);
  endtask

  task automatic m_bit_r(output bit b);
    sda_m = 1; wq(Q); scl_m = 1; wait_high(); wq(Q); b = sda_line; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic m_wbyte(logic [7:0] d, bit race, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) m_bit_w(d[i], race && (i == 0));
    m_bit_r(b);
    ack = !b;
  endtask

  task automatic m_rbyte(bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_r(b);
      d[i] = b;
    end
    m_bit_w(!give_ack, 0);
  endtask

  task automatic drain();
    rx_ready = 1; wq(1); rx_ready = 0; wq(1);
  endtask

  // host side of the read path
  initial begin
    tx_valid = 0; tx_data = 0; scl_release = 0;
    forever begin
      @(negedge clk);
      if (sw_en && scl_oe) begin
        wq(5);
        if (sw_empty_try) begin
          scl_release = 1; wq(1); scl_release = 0; wq(20);
          chk(scl_oe == 1, "R9 release with empty register ignored", scl_oe, 1);
          sw_empty_try = 0;
        end
        tx_valid = 1; tx_data = tx_bytes[sw_idx]; wq(1); tx_valid = 0;
        chk(tx_ready == 0, "R10 register full after load", tx_ready, 0);
        scl_release = 1; wq(1); scl_release = 0; wq(1);
        chk(scl_oe == 0, "R9 clock let go after release", scl_oe, 0);
        chk(tx_ready == 1, "R10 register taken at release", tx_ready, 1);
        sw_idx++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack, good, m10, hit;
    logic [7:0] a, d, d0, d1, old;
    logic [9:0] own;
    int h0, i0, n;
    int unsigned seed;
    seed = $urandom(32'd5171);
    addr_mode10 = 0; own_addr = 10'h055; rx_ready = 0;
    wq(5); rst_n = 1; wq(2);

    // R1
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(rx_valid == 0 && rx_ovf == 0 && irq == 0, "R1 rx idle", {rx_valid, rx_ovf, irq}, 0);
    chk(tx_ready == 1, "R1 tx empty", tx_ready, 1);

    // R2 / R5: 7-bit write
    own = 10'h1A3; own_addr = own; addr_mode10 = 0;
    m_start(); m_wbyte({own[6:0], 1'b0}, 0, ack);
    chk(ack == 1, "R2 7-bit match ACK", ack, 1);
    i0 = irq_cnt;
    m_wbyte(8'hC6, 0, ack);
    chk(ack == 1, "R5 data ACK", ack, 1);
    chk(rx_valid && rx_data == 8'hC6, "R5 byte delivered", rx_data, 8'hC6);
    chk(irq_cnt - i0 == 1, "R5 irq pulse", irq_cnt - i0, 1);
    drain();
    m_stop();

    // R2 mismatch
    m_start(); m_wbyte({own[6:0] ^ 7'h08, 1'b0}, 0, ack);
    chk(ack == 0, "R2 mismatch NACK", ack, 0);
    m_wbyte(8'h5A, 0, ack);
    chk(ack == 0 && rx_valid == 0, "R2 bytes ignored after mismatch", {ack, rx_valid}, 0);
    m_stop();

    // R3 10-bit write, R6 overflow, R7 same-cycle drain
    own = 10'h2B5; own_addr = own; addr_mode10 = 1;
    m_start(); m_wbyte({5'b11110, own[9:8], 1'b0}, 0, ack);
    chk(ack == 1, "R3 header ACK", ack, 1);
    m_wbyte(own[7:0], 0, ack);
    chk(ack == 1, "R3 low byte ACK", ack, 1);
    m_wbyte(8'h11, 0, ack);
    chk(ack == 1 && rx_data == 8'h11, "R3 data after 10-bit match", rx_data, 8'h11);
    m_wbyte(8'h22, 0, ack);
    chk(ack == 0, "R6 full buffer NACK", ack, 0);
    chk(rx_ovf == 1 && rx_data == 8'h11, "R6 overflow keeps old", {rx_ovf, rx_data}, {1'b1, 8'h11});
    m_wbyte(8'h33, 1, ack);
    chk(ack == 1, "R7 same-cycle drain ACK", ack, 1);
    chk(rx_valid && rx_data == 8'h33, "R7 new byte replaces drained", rx_data, 8'h33);
    chk(rx_ovf == 1, "R6 overflow sticky until START", rx_ovf, 1);
    drain();
    m_rstart();
    chk(rx_ovf == 0, "R6 overflow cleared by START", rx_ovf, 0);
    m_wbyte({5'b11110, own[9:8], 1'b0}, 0, ack);
    m_wbyte(own[7:0] ^ 8'h10, 0, ack);
    chk(ack == 0, "R3 low byte mismatch NACK", ack, 0);
    m_stop();

    // R4 / R8 / R9 / R10: 10-bit read by repeated START
    m_start(); m_wbyte({5'b11110, own[9:8], 1'b0}, 0, ack);
    m_wbyte(own[7:0], 0, ack);
    m_rstart();
    tx_bytes[0] = 8'hA5; tx_bytes[1] = 8'h3C; sw_idx = 0; sw_empty_try = 1; sw_en = 1;
    h0 = hold_cnt; i0 = irq_cnt;
    m_wbyte({5'b11110, own[9:8], 1'b1}, 0, ack);
    chk(ack == 1, "R4 short header read ACK", ack, 1);
    m_rbyte(1, d0);
    chk(d0 == 8'hA5, "R10 first read byte", d0, 8'hA5);
    m_rbyte(0, d1);
    chk(d1 == 8'h3C, "R10 second read byte", d1, 8'h3C);
    m_stop();
    chk(hold_cnt - h0 == 2, "R8 holds per read", hold_cnt - h0, 2);
    chk(irq_cnt - i0 == 2, "R8 irq per hold", irq_cnt - i0, 2);
    chk(scl_oe == 0, "R10 NACK ends read", scl_oe, 0);
    sw_en = 0;

    // R4 without prior match
    m_start(); m_wbyte({5'b11110, own[9:8], 1'b1}, 0, ack);
    chk(ack == 0, "R4 header read without match NACK", ack, 0);
    m_stop();

    // R8 / R10: 7-bit read with random byte
    addr_mode10 = 0; own = 10'($urandom); own_addr = own;
    tx_bytes[0] = 8'($urandom); sw_idx = 0; sw_en = 1;
    h0 = hold_cnt;
    m_start(); m_wbyte({own[6:0], 1'b1}, 0, ack);
    chk(ack == 1, "R2 7-bit read address ACK", ack, 1);
    m_rbyte(0, d0);
    chk(d0 == tx_bytes[0], "R10 7-bit read byte", d0, tx_bytes[0]);
    m_stop();
    chk(hold_cnt - h0 == 1, "R8 single hold", hold_cnt - h0, 1);
    sw_en = 0;

    // random writes
    for (int it = 0; it < 8; it++) begin
      m10 = 1'($urandom); own = 10'($urandom); hit = ($urandom % 4) != 0;
      addr_mode10 = m10; own_addr = own; wq(2);
      m_start();
      if (!m10) begin
        a = hit ? {own[6:0], 1'b0} : {own[6:0] ^ 7'h11, 1'b0};
        m_wbyte(a, 0, ack);
        chk(ack == exp_hdr(0, own, a, 0), "R2 random address", ack, exp_hdr(0, own, a, 0));
      end else begin
        a = {5'b11110, own[9:8], 1'b0};
        m_wbyte(a, 0, ack);
        chk(ack == exp_hdr(1, own, a, 0), "R3 random header", ack, 1);
        a = hit ? own[7:0] : own[7:0] ^ 8'h40;
        m_wbyte(a, 0, ack);
        chk(ack == exp_low(own, a), "R3 random low byte", ack, exp_low(own, a));
      end
      good = ack;
      n = 1 + ($urandom % 3);
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        old = rx_data;
        m_wbyte(d, 0, ack);
        chk(ack == good, "R5 random data ACK", ack, good);
        if (good) begin
          chk(rx_valid && rx_data == d, "R5 random data", rx_data, d);
          drain();
        end else chk(rx_valid == 0 && rx_data == old, "R2 random ignored", rx_valid, 0);
      end
      m_stop();
    end

    chk(r11_viol == 0, "R11 data driven only while clock low", r11_viol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule